// File: doc/BRIEF.md
# DRAM Power-Up and Refresh Sequencer

This block owns the start-up and refresh strobes of a 36-bit asynchronous DRAM module built from x4 and x1 devices. The module has four row strobes, four column strobes, one write enable and a multiplexed row address. Out of reset the sequencer keeps every strobe inactive for a power-stabilization pause. It then runs a burst of CAS-before-RAS refresh cycles, which serve as the module's initialization cycles. After that it keeps the stored data alive by issuing one refresh cycle per refresh interval.

Once initialization is complete, refresh cycles compete with normal accesses for the shared strobes. The sequencer raises a request to the access sequencer and starts its cycle only after a grant. The interval timer keeps running while the request waits, so a refresh that falls due during a long access is held and issued right after the grant arrives. A done flag gates access requests from the host until initialization has finished.

Every analog minimum (pause, CAS lead, CAS hold, RAS pulse, RAS precharge, refresh interval) is given in nanoseconds. Each is converted to clock cycles by rounding up against the clock-period parameter. The RAS pulse and precharge minimums come from a speed-grade parameter.

Top module: `dram_rfsh_seq`

## Requirements
- R1: After reset is released, all RAS and CAS strobes stay high (inactive) for at least the pause time (PAUSE_NS) before any strobe falls.
- R2: After the pause, at least INIT_CNT (default 8) refresh cycles are issued without waiting for the grant input, and init_done rises only after they complete.
- R3: host_accept is 1 only when host_req is 1 and init_done is 1. init_done never falls again before the next reset.
- R4: Every refresh cycle is CAS-before-RAS: all CAS strobes are low for at least ceil(5 ns / clock) cycles before the RAS strobes fall.
- R5: In each refresh cycle, RAS stays low for at least the speed-grade RAS pulse minimum (60/70/80 ns for grade 0/1/2). CAS stays low for at least ceil(10 ns / clock) cycles after RAS falls.
- R6: Between two refresh cycles, RAS stays high for at least the speed-grade precharge minimum (40/50/60 ns for grade 0/1/2).
- R7: we_n is always 1. The four RAS outputs always carry the same value, and so do the four CAS outputs.
- R8: addr holds a binary refresh row counter that starts at 0 and increases by one after each refresh cycle, wrapping at 2^ADDR_W. The most significant bit therefore changes least often, and the lower ADDR_W-1 bits run through all their values every 2^(ADDR_W-1) refreshes. The value on addr when RAS falls is the row being refreshed.
- R9: After init, with the grant held high, two consecutive refresh cycles start no more than ceil(REFRESH_NS / clock) cycles apart.
- R10: A due refresh raises rfsh_req, and rfsh_req stays high until the grant is given. The pending refresh is held however long the grant is withheld. Exactly one refresh cycle starts within two cycles of the grant, and rfsh_req falls while that cycle runs.
- R11: While reset is active, all strobes are high, init_done, rfsh_req and host_accept are 0, and addr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rfsh_gnt | input | 1 | Grant from the shared access sequencer |
| host_req | input | 1 | Access request from the host side |
| ras_n | output | NUM_RAS | Row strobes, active low |
| cas_n | output | NUM_CAS | Column strobes, active low |
| we_n | output | 1 | Write enable, held high |
| addr | output | ADDR_W | Refresh row address |
| rfsh_req | output | 1 | Refresh wants the strobes |
| init_done | output | 1 | Initialization complete |
| host_accept | output | 1 | Host access allowed |

## Verification
The hardest case to reach is a refresh that falls due while the grant is withheld for much longer than one refresh interval. Only under that condition can the pending refresh be lost, duplicated or released too late. The bench drops the grant once the steady refresh stream is running and waits for the request. It then holds the grant low for well over two intervals and confirms that no RAS activity occurs and that the request stays high. It then restores the grant and counts exactly one refresh. A short pause and interval with a 5-bit row counter let a single run cover more than one full wrap of the rows.

// File: rtl/dram_rfsh_pkg.sv
package dram_rfsh_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_CAS,
        ST_RAS,
        ST_PRE,
        ST_IDLE
    } seq_st_e;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
    } strobe_t;

    localparam int unsigned CAS_LEAD_NS = 5;
    localparam int unsigned CAS_HOLD_NS = 10;

    function automatic int unsigned ns_to_cyc(input longint unsigned ns,
                                              input longint unsigned clk_ps);
        longint unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c == 0) c = 1;
        return int'(c);
    endfunction

    function automatic int unsigned ras_pulse_ns(input int unsigned grade);
        case (grade)
            0:       return 60;
            1:       return 70;
            default: return 80;
        endcase
    endfunction

    function automatic int unsigned ras_pre_ns(input int unsigned grade);
        case (grade)
            0:       return 40;
            1:       return 50;
            default: return 60;
        endcase
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/drs_interval_timer.sv
module drs_interval_timer #(
    parameter int unsigned INT_CYC = 1950
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic clr,
    output logic pend
);
    localparam int unsigned CW = $clog2(INT_CYC + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = run && (cnt == CW'(INT_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            pend <= 1'b0;
        end else begin
            if (run) cnt <= tick ? '0 : cnt + 1'b1;
            if (tick)     pend <= 1'b1;
            else if (clr) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/drs_row_ctr.sv
module drs_row_ctr #(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    output logic [ADDR_W-1:0] row
);
    always_ff @(posedge clk) begin
        if (rst)       row <= '0;
        else if (step) row <= row + 1'b1;
    end
endmodule

// File: rtl/drs_strobe_fsm.sv
module drs_strobe_fsm
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned PAUSE_CYC = 25000,
    parameter int unsigned CSR_CYC   = 1,
    parameter int unsigned CHR_CYC   = 2,
    parameter int unsigned RAS_CYC   = 8,
    parameter int unsigned RP_CYC    = 5,
    parameter int unsigned INIT_CNT  = 8
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    go,
    output strobe_t strobe,
    output logic    take,
    output logic    cyc_done,
    output logic    idle,
    output logic    init_done
);
    localparam int unsigned MAXC = max2(max2(PAUSE_CYC, CSR_CYC), max2(RAS_CYC, RP_CYC));
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam int unsigned IW   = $clog2(INIT_CNT + 1);

    seq_st_e       st;
    logic [CW-1:0] cnt;
    logic [IW-1:0] icnt;

    assign idle     = (st == ST_IDLE);
    assign take     = idle && go;
    assign cyc_done = (st == ST_PRE) && (cnt == CW'(RP_CYC - 1));

    always_comb begin
        strobe.ras_n = (st != ST_RAS);
        strobe.cas_n = !((st == ST_CAS) || ((st == ST_RAS) && (cnt < CW'(CHR_CYC))));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_PAUSE;
            cnt       <= '0;
            icnt      <= '0;
            init_done <= 1'b0;
        end else begin
            case (st)
                ST_PAUSE: begin
                    if (cnt == CW'(PAUSE_CYC - 1)) begin
                        st  <= ST_CAS;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_CAS: begin
                    if (cnt == CW'(CSR_CYC - 1)) begin
                        st  <= ST_RAS;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_RAS: begin
                    if (cnt == CW'(RAS_CYC - 1)) begin
                        st  <= ST_PRE;
                        cnt <= '0;
                    end else cnt <= cnt + 1'b1;
                end
                ST_PRE: begin
                    if (cyc_done) begin
                        cnt <= '0;
                        if (init_done) begin
                            st <= ST_IDLE;
                        end else if (icnt == IW'(INIT_CNT - 1)) begin
                            init_done <= 1'b1;
                            st        <= ST_IDLE;
                        end else begin
                            icnt <= icnt + 1'b1;
                            st   <= ST_CAS;
                        end
                    end else cnt <= cnt + 1'b1;
                end
                ST_IDLE: begin
                    if (go) st <= ST_CAS;
                end
                default: st <= ST_PAUSE;
            endcase
        end
    end
endmodule

// File: rtl/dram_rfsh_seq.sv
module dram_rfsh_seq
    import dram_rfsh_pkg::*;
#(
    parameter int unsigned CLK_PS      = 8000,
    parameter int unsigned SPEED_GRADE = 0,
    parameter int unsigned PAUSE_NS    = 200000,
    parameter int unsigned REFRESH_NS  = 15600,
    parameter int unsigned INIT_CNT    = 8,
    parameter int unsigned ADDR_W      = 11,
    parameter int unsigned NUM_RAS     = 4,
    parameter int unsigned NUM_CAS     = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rfsh_gnt,
    input  logic               host_req,
    output logic [NUM_RAS-1:0] ras_n,
    output logic [NUM_CAS-1:0] cas_n,
    output logic               we_n,
    output logic [ADDR_W-1:0]  addr,
    output logic               rfsh_req,
    output logic               init_done,
    output logic               host_accept
);
    localparam int unsigned PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_PS);
    localparam int unsigned CSR_CYC   = ns_to_cyc(CAS_LEAD_NS, CLK_PS);
    localparam int unsigned CHR_CYC   = ns_to_cyc(CAS_HOLD_NS, CLK_PS);
    localparam int unsigned RAS_CYC   = max2(ns_to_cyc(ras_pulse_ns(SPEED_GRADE), CLK_PS), CHR_CYC + 1);
    localparam int unsigned RP_CYC    = ns_to_cyc(ras_pre_ns(SPEED_GRADE), CLK_PS);
    localparam int unsigned INT_CYC   = ns_to_cyc(REFRESH_NS, CLK_PS);

    strobe_t strb;
    logic    pend, take, cyc_done, idle;

    drs_interval_timer #(.INT_CYC(INT_CYC)) timer_i (
        .clk  (clk),
        .rst  (rst),
        .run  (init_done),
        .clr  (take),
        .pend (pend)
    );

    drs_strobe_fsm #(
        .PAUSE_CYC (PAUSE_CYC),
        .CSR_CYC   (CSR_CYC),
        .CHR_CYC   (CHR_CYC),
        .RAS_CYC   (RAS_CYC),
        .RP_CYC    (RP_CYC),
        .INIT_CNT  (INIT_CNT)
    ) fsm_i (
        .clk       (clk),
        .rst       (rst),
        .go        (pend && rfsh_gnt),
        .strobe    (strb),
        .take      (take),
        .cyc_done  (cyc_done),
        .idle      (idle),
        .init_done (init_done)
    );

    drs_row_ctr #(.ADDR_W(ADDR_W)) row_i (
        .clk  (clk),
        .rst  (rst),
        .step (cyc_done),
        .row  (addr)
    );

    for (genvar g = 0; g < NUM_RAS; g++) begin : g_ras
        assign ras_n[g] = strb.ras_n;
    end
    for (genvar g = 0; g < NUM_CAS; g++) begin : g_cas
        assign cas_n[g] = strb.cas_n;
    end

    assign we_n        = 1'b1;
    assign rfsh_req    = pend && idle;
    assign host_accept = host_req && init_done;
endmodule

// File: rtl/drs_checker.sv
module drs_checker #(
    parameter int unsigned NUM_RAS   = 4,
    parameter int unsigned NUM_CAS   = 4,
    parameter int unsigned ADDR_W    = 11,
    parameter int unsigned PAUSE_CYC = 25000
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_RAS-1:0] ras_n,
    input logic [NUM_CAS-1:0] cas_n,
    input logic [ADDR_W-1:0]  addr,
    input logic               rfsh_req,
    input logic               rfsh_gnt,
    input logic               host_req,
    input logic               host_accept,
    input logic               init_done
);
    localparam int unsigned PW = $clog2(PAUSE_CYC + 1);

    logic [PW-1:0] pcnt;
    always_ff @(posedge clk) begin
        if (rst) pcnt <= '0;
        else if (pcnt != PW'(PAUSE_CYC)) pcnt <= pcnt + 1'b1;
    end

    AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (pcnt < PW'(PAUSE_CYC)) |-> (ras_n == '1 && cas_n == '1)); // R1

    AST_ACCEPT_GATED: assert property (@(posedge clk) disable iff (rst)
        (!init_done || !host_req) |-> !host_accept); // R3

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done); // R3

    AST_CAS_LEADS_RAS: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n[0]) |-> (cas_n == '0 && $past(cas_n) == '0)); // R4

    AST_STROBE_UNIFORM: assert property (@(posedge clk) disable iff (rst)
        (ras_n == '0 || ras_n == '1) && (cas_n == '0 || cas_n == '1)); // R7

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (addr != $past(addr)) |-> (addr == ADDR_W'($past(addr) + 1'b1))); // R8

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (rfsh_req && !rfsh_gnt) |=> rfsh_req); // R10
endmodule

bind dram_rfsh_seq drs_checker #(
    .NUM_RAS   (NUM_RAS),
    .NUM_CAS   (NUM_CAS),
    .ADDR_W    (ADDR_W),
    .PAUSE_CYC (PAUSE_CYC)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .ras_n       (ras_n),
    .cas_n       (cas_n),
    .addr        (addr),
    .rfsh_req    (rfsh_req),
    .rfsh_gnt    (rfsh_gnt),
    .host_req    (host_req),
    .host_accept (host_accept),
    .init_done   (init_done)
);

// File: tb/dram_rfsh_seq_tb.sv
`timescale 1ns/1ps
module dram_rfsh_seq_tb_top;
    localparam int CLK_PS = 8000;
    localparam int PAUSE_NS = 800;
    localparam int REFRESH_NS = 480;
    localparam int ADDR_W = 5;
    localparam int INIT_N = 8;
    localparam int E_CSR = (5 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int E_CHR = (10 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RAS = (60 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int E_RP  = (40 * 1000 + CLK_PS - 1) / CLK_PS;
    localparam int E_INT = (REFRESH_NS * 1000 + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0, rst = 1'b1, rfsh_gnt = 1'b0, host_req = 1'b1;
    logic [3:0] ras_n, cas_n;
    logic we_n, rfsh_req, init_done, host_accept;
    logic [ADDR_W-1:0] addr;

    always #4 clk = ~clk;

    dram_rfsh_seq #(.CLK_PS(CLK_PS), .SPEED_GRADE(0), .PAUSE_NS(PAUSE_NS),
        .REFRESH_NS(REFRESH_NS), .INIT_CNT(INIT_N), .ADDR_W(ADDR_W),
        .NUM_RAS(4), .NUM_CAS(4)) dut_i (
        .clk(clk), .rst(rst), .rfsh_gnt(rfsh_gnt), .host_req(host_req),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr),
        .rfsh_req(rfsh_req), .init_done(init_done), .host_accept(host_accept));

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // monitor state
    int nfall = 0, exp_row = 0, ras_lo = 0, ras_hi = 0, cas_lo = 0, fall_age = 0, gap = 0;
    bit prev_ras = 1, prev_cas = 1, seen_fall = 0, first_cas = 0, done_seen = 0;
    bit steady = 0, gap_ok = 0;
    realtime t_rel = 0;

    always @(negedge clk) begin
        if (!rst) begin
            chk(we_n == 1'b1, "R7 we_n", we_n, 1);
            chk(ras_n == 4'h0 || ras_n == 4'hF, "R7 ras uniform", ras_n, {4{ras_n[0]}});
            chk(cas_n == 4'h0 || cas_n == 4'hF, "R7 cas uniform", cas_n, {4{cas_n[0]}});
            if (!first_cas && (!cas_n[0] || !ras_n[0])) begin
                first_cas = 1;
                chk(($realtime - t_rel) >= PAUSE_NS, "R1 pause",
                    int'($realtime - t_rel), PAUSE_NS);
            end
            if (!steady) gap_ok = 0;
            if (prev_ras && !ras_n[0]) begin
                chk(cas_lo >= E_CSR, "R4 cas lead", cas_lo, E_CSR);
                if (seen_fall) chk(ras_hi >= E_RP, "R6 precharge", ras_hi, E_RP);
                chk(addr == ADDR_W'(exp_row % (1 << ADDR_W)), "R8 row", addr,
                    exp_row % (1 << ADDR_W));
                if (steady && gap_ok) chk(gap <= E_INT, "R9 interval", gap, E_INT);
                gap_ok = steady;
                exp_row++;
                nfall++;
                seen_fall = 1;
                gap = 0;
                fall_age = 0;
            end else if (!prev_ras && ras_n[0]) begin
                chk(ras_lo >= E_RAS, "R5 ras pulse", ras_lo, E_RAS);
            end
            if (!prev_ras && !ras_n[0] && !prev_cas && cas_n[0])
                chk(fall_age >= E_CHR, "R5 cas hold", fall_age, E_CHR);
            if (init_done && !done_seen) begin
                done_seen = 1;
                chk(nfall >= INIT_N, "R2 init cycles", nfall, INIT_N);
            end
            ras_lo = ras_n[0] ? 0 : ras_lo + 1;
            ras_hi = ras_n[0] ? ras_hi + 1 : 0;
            cas_lo = cas_n[0] ? 0 : cas_lo + 1;
            fall_age++;
            gap++;
            prev_ras = ras_n[0];
            prev_cas = cas_n[0];
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int n0;
        repeat (4) @(negedge clk);
        // R11 reset state
        chk(ras_n == 4'hF, "R11 ras_n", ras_n, 15);
        chk(cas_n == 4'hF, "R11 cas_n", cas_n, 15);
        chk(init_done == 0, "R11 init_done", init_done, 0);
        chk(rfsh_req == 0, "R11 rfsh_req", rfsh_req, 0);
        chk(addr == 0, "R11 addr", addr, 0);
        chk(host_accept == 0, "R11 host_accept", host_accept, 0);
        rst = 1'b0;
        t_rel = $realtime;
        // R2: init proceeds with grant low; R3: no accept meanwhile
        while (!init_done) begin
            @(negedge clk);
            #1 chk(host_accept == 0 || init_done, "R3 refused before init", host_accept, 0);
        end
        #1 chk(host_accept == 1, "R3 accept after init", host_accept, 1);
        host_req = 1'b0;
        #1 chk(host_accept == 0, "R3 no req", host_accept, 0);
        chk(addr == ADDR_W'(INIT_N), "R8 row after init", addr, INIT_N);
        @(negedge clk);
        rfsh_gnt = 1'b1;
        steady = 1;
        // run across more than one full row wrap
        while (nfall < INIT_N + 36) @(negedge clk);
        chk(init_done == 1, "R3 done sticky", init_done, 1);
        // R10 grant withheld
        steady = 0;
        rfsh_gnt = 1'b0;
        while (!rfsh_req) @(negedge clk);
        n0 = nfall;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (!rfsh_req || nfall != n0) begin
                chk(0, "R10 held while no grant", nfall, n0);
                break;
            end
        end
        chk(rfsh_req == 1, "R10 req still high", rfsh_req, 1);
        rfsh_gnt = 1'b1;
        repeat (3) @(negedge clk);
        chk(nfall == n0 + 1, "R10 one refresh after grant", nfall, n0 + 1);
        chk(rfsh_req == 0, "R10 req dropped", rfsh_req, 0);
        repeat (20) @(negedge clk);
        chk(nfall == n0 + 1, "R10 no duplicate", nfall, n0 + 1);
        steady = 1;
        n0 = nfall;
        while (nfall < n0 + 3) @(negedge clk);
        chk(1, "R9 resumed", nfall, n0 + 3);
        finish_run();
    end
endmodule